// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block serialises characters onto an asynchronous serial line. Software, or a bus decoder outside the block, writes a character into a one-entry holding register. On a later bit-time tick the framer moves it into a shift register and sends a frame on the line. A frame is a start bit, five to eight data bits sent least significant bit first, an optional parity bit and one, one-and-a-half or two stop bits. A 7-bit line control word selects the frame shape. Baud-rate division happens outside: the block only advances on `tick_i`. That strobe pulses `TICKS_PER_BIT` times per bit period; the default is two, which gives the half-bit steps needed for 1.5 stop bits.

The line control word also carries a break bit. It pulls the line low while the framing logic keeps running underneath. Because of this, a character that is sent while the break is held can be used to time how long the break lasts.

Two flags come out of the block, and both are suitable as interrupt sources. The holding-empty flag says a new character may be written. The transmitter-empty flag says the line has gone quiet and no work is left.

Top module: `uart_tx_framer`

## Requirements
- R1: After a load, the line sends a 0 start bit and then `5 + lcr_i[1:0]` data bits, least significant bit first. The codes 00, 01, 10 and 11 give 5, 6, 7 and 8 bits. Each bit holds the line for `TICKS_PER_BIT` ticks, and the line changes only on a tick or on a change of the break bit.
- R2: The stop period after the last data or parity bit is high. It lasts one bit when `lcr_i[2]` is 0, 1.5 bits when `lcr_i[2]` is 1 with a 5-bit word, and 2 bits when `lcr_i[2]` is 1 with a 6, 7 or 8-bit word.
- R3: When `lcr_i[3]` is 1, a parity bit follows the last data bit. With `lcr_i[4]` at 0 the parity is odd, meaning the data bits plus the parity bit hold an odd number of ones. With `lcr_i[4]` at 1 the parity is even.
- R4: When `lcr_i[3]` and `lcr_i[5]` are both 1, the parity bit is the inverse of `lcr_i[4]`, whatever the data.
- R5: While `lcr_i[6]` is 1, `txd_o` is 0. The frame keeps its timing underneath: the transmitter-empty flag rises on the same tick as it would without the break, and once the break bit clears, the line shows the rest of the frame.
- R6: `thr_empty_o` falls in the cycle after a write. It rises again in the cycle after the tick that moves the character into the shift register.
- R7: `tx_empty_o` is 1 only when both the holding register and the shift register are empty. It rises only after a tick.
- R8: After reset, `txd_o`, `thr_empty_o` and `tx_empty_o` are all 1. The line stays high whenever nothing is being sent and no break is requested.
- R9: A character written while the shift register is idle waits for the next tick, and is loaded on that tick. A character that is pending at the end of a frame is loaded on the very tick where the previous stop period ends, so its start bit follows the stop period with no gap.
- R10: A write while the holding register is already full overwrites the waiting character. Only the last character written is sent.
- R11: The word length, stop and parity fields are captured when a character is loaded. The break bit acts on the line at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-bit timing strobe, TICKS_PER_BIT per bit period |
| wr_i | input | 1 | Holding register write strobe |
| wr_data_i | input | MAX_WORD | Character to write; bits above the word length are ignored |
| lcr_i | input | 7 | Line control: [1:0] length, [2] stop, [3] parity enable, [4] even, [5] stick, [6] break |
| txd_o | output | 1 | Serial line |
| thr_empty_o | output | 1 | Holding register free |
| tx_empty_o | output | 1 | Holding and shift registers both empty |

## Verification
The bench builds the block with its defaults: `TICKS_PER_BIT` of 2 and a widest word of 8 bits. This puts the whole control space within reach, so all 64 settings of the framing fields are swept, each with four data patterns. Every half-bit of each frame is compared with a frame computed arithmetically in the bench, and the end tick is checked against each stop-length rule. Further runs cover back-to-back frames with an overwritten pending character, a break held for a whole frame, and a break released partway through a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int WLEN_W   = 2;
  localparam int MIN_WORD = 5;
  localparam int MAX_WORD = MIN_WORD + (1 << WLEN_W) - 1;
  // start + data + parity + two stop bits
  localparam int FRAME_W  = MAX_WORD + 4;

  typedef struct packed {
    logic              brk;
    logic              stick;
    logic              even;
    logic              par_en;
    logic              stop2;
    logic [WLEN_W-1:0] wlen;
  } line_ctrl_t;

  localparam int CTRL_W = $bits(line_ctrl_t);
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else begin
      if (wr_i) data_o <= data_i;
      // a write in the take cycle leaves a fresh character behind
      if (wr_i)        full_o <= 1'b1;
      else if (take_i) full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_frame_build.sv
module uart_tx_frame_build
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 2,
  parameter int CNT_W         = 5
) (
  input  logic [MAX_WORD-1:0] data_i,
  input  line_ctrl_t          ctrl_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [CNT_W-1:0]    ticks_o
);
  localparam int HALF = TICKS_PER_BIT / 2;

  int   wl;
  int   stop_t;
  logic par;
  logic pbit;

  always_comb begin
    wl      = MIN_WORD + int'(ctrl_i.wlen);
    frame_o = '1;
    frame_o[0] = 1'b0;
    par = 1'b0;
    for (int i = 0; i < MAX_WORD; i++) begin
      if (i < wl) begin
        frame_o[i+1] = data_i[i];
        par          = par ^ data_i[i];
      end
    end
    pbit = ctrl_i.stick ? ~ctrl_i.even : (ctrl_i.even ? par : ~par);
    for (int j = 1; j < FRAME_W; j++) begin
      if (ctrl_i.par_en && (j == wl + 1)) frame_o[j] = pbit;
    end
    if (!ctrl_i.stop2)          stop_t = TICKS_PER_BIT;
    else if (wl == MIN_WORD)    stop_t = TICKS_PER_BIT + HALF;
    else                        stop_t = 2 * TICKS_PER_BIT;
    ticks_o = CNT_W'(TICKS_PER_BIT * (1 + wl + int'(ctrl_i.par_en)) + stop_t);
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 2,
  parameter int CNT_W         = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   ticks_i,
  output logic               busy_o,
  output logic               last_o,
  output logic               line_o
);
  localparam int PH_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_BIT - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PH_W-1:0]    ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      ph_q   <= '0;
      busy_o <= 1'b0;
    end else if (tick_i) begin
      if (load_i) begin
        sh_q   <= frame_i;
        cnt_q  <= ticks_i;
        ph_q   <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (last_o) begin
          busy_o <= 1'b0;
          sh_q   <= '1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          if (ph_q == PH_LAST) begin
            ph_q <= '0;
            sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
      end
    end
  end

  assign last_o = busy_o && (cnt_q == CNT_W'(1));
  assign line_o = sh_q[0];
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_i,
  input  logic [MAX_WORD-1:0] wr_data_i,
  input  logic [CTRL_W-1:0]   lcr_i,
  output logic                txd_o,
  output logic                thr_empty_o,
  output logic                tx_empty_o
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT * FRAME_W + 1);

  line_ctrl_t          ctrl;
  logic [MAX_WORD-1:0] hold_data;
  logic                hold_full;
  logic                take;
  logic                busy;
  logic                last;
  logic                line;
  logic [FRAME_W-1:0]  frame;
  logic [CNT_W-1:0]    ticks;

  assign ctrl = line_ctrl_t'(lcr_i);
  assign take = tick_i && hold_full && (!busy || last);

  uart_tx_hold #(.DATA_W(MAX_WORD)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .data_i (wr_data_i),
    .take_i (take),
    .data_o (hold_data),
    .full_o (hold_full)
  );

  uart_tx_frame_build #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) i_build (
    .data_i  (hold_data),
    .ctrl_i  (ctrl),
    .frame_o (frame),
    .ticks_o (ticks)
  );

  uart_tx_shift #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .load_i  (take),
    .frame_i (frame),
    .ticks_i (ticks),
    .busy_o  (busy),
    .last_o  (last),
    .line_o  (line)
  );

  assign txd_o       = line && !ctrl.brk;
  assign thr_empty_o = !hold_full;
  assign tx_empty_o  = !hold_full && !busy;
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk
  import uart_tx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [CTRL_W-1:0] lcr_i,
  input logic              txd_o,
  input logic              thr_empty_o,
  input logic              tx_empty_o
);
  assert_temt_needs_thre_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> thr_empty_o);

  assert_temt_rise_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(tick_i));

  assert_break_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_i[6] |-> !txd_o);

  assert_idle_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && !lcr_i[6]) |-> txd_o);

  assert_write_fills_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !thr_empty_o);

  assert_load_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thr_empty_o) |-> $past(tick_i));

  assert_line_steady_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && $stable(lcr_i[6])) |-> $stable(txd_o));
endmodule

bind uart_tx_framer uart_tx_framer_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .wr_i        (wr_i),
  .lcr_i       (lcr_i),
  .txd_o       (txd_o),
  .thr_empty_o (thr_empty_o),
  .tx_empty_o  (tx_empty_o)
);

// File: tb/test_uart_tx_framer.sv
`timescale 1ns/1ps
module test_uart_tx_framer;
  localparam int TPB = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [6:0] lcr_i = '0;
  logic       txd_o, thr_empty_o, tx_empty_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_tx_framer #(.TICKS_PER_BIT(TPB)) i_uart_tx_framer (
    .clk_i, .rst_ni, .tick_i, .wr_i, .wr_data_i, .lcr_i,
    .txd_o, .thr_empty_o, .tx_empty_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int wlen(input logic [5:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic int nticks(input logic [5:0] c);
    int st;
    st = !c[2] ? TPB : (wlen(c) == 5 ? TPB + TPB/2 : 2*TPB);
    return TPB * (1 + wlen(c) + int'(c[3])) + st;
  endfunction

  // expected line level for bit slot idx of a frame
  function automatic logic ebit(input logic [5:0] c, input logic [7:0] d, input int idx);
    int ones;
    ones = 0;
    for (int i = 0; i < wlen(c); i++) ones += int'(d[i]);
    if (idx == 0) return 1'b0;
    if (idx <= wlen(c)) return d[idx-1];
    if (idx == wlen(c) + 1 && c[3]) begin
      if (c[5]) return ~c[4];
      return c[4] ? logic'(ones % 2) : logic'(~(ones % 2));
    end
    return 1'b1;
  endfunction

  function automatic string tag(input logic [5:0] c, input int idx);
    if (idx <= wlen(c)) return "R1";
    if (idx == wlen(c) + 1 && c[3]) return c[5] ? "R4" : "R3";
    return "R2";
  endfunction

  task automatic tick1;
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
  endtask

  task automatic wr1(input logic [7:0] d);
    @(negedge clk_i) begin wr_i = 1'b1; wr_data_i = d; end
    @(negedge clk_i) wr_i = 1'b0;
  endtask

  // next tick must be the load tick of (c, d)
  task automatic run_frame(input logic [5:0] c, input logic [7:0] d, input int brk_until,
                           input bit mid_wr, input logic [7:0] b_d, input logic [7:0] c_d);
    int n;
    n = nticks(c);
    for (int k = 0; k < n; k++) begin
      lcr_i = {logic'(k < brk_until), c};
      tick1();
      if (k < brk_until) chk("R5 break line", int'(txd_o), 0);
      else chk(tag(c, k / TPB), int'(txd_o), int'(ebit(c, d, k / TPB)));
      chk("R7 busy not empty", int'(tx_empty_o), 0);
      if (k == 0) chk("R6 thre after load", int'(thr_empty_o), 1);
      if (mid_wr && k == 2) begin
        wr1(b_d);
        chk("R6 thre after write", int'(thr_empty_o), 0);
        wr1(c_d);
      end
      if (mid_wr && k == n - 1) chk("R10 pending kept", int'(thr_empty_o), 0);
    end
  endtask

  task automatic finish_frame(input int brk);
    lcr_i[6] = logic'(brk);
    tick1();
    chk("R2 end tick temt", int'(tx_empty_o), 1);
    chk("R7 thre at end", int'(thr_empty_o), 1);
    chk("R8 line after frame", int'(txd_o), brk ? 0 : 1);
    lcr_i[6] = 1'b0;
  endtask

  task automatic single(input logic [5:0] c, input logic [7:0] d);
    lcr_i = {1'b0, c};
    wr1(d);
    chk("R6 thre low", int'(thr_empty_o), 0);
    run_frame(c, d, 0, 1'b0, 8'h00, 8'h00);
    finish_frame(0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R8 reset txd", int'(txd_o), 1);
    chk("R8 reset thre", int'(thr_empty_o), 1);
    chk("R8 reset temt", int'(tx_empty_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9: pending character waits for a tick
    lcr_i = 7'h03;
    wr1(8'h5A);
    repeat (5) @(negedge clk_i);
    chk("R9 no tick no start", int'(txd_o), 1);
    chk("R9 no tick still full", int'(thr_empty_o), 0);
    chk("R7 full not empty", int'(tx_empty_o), 0);
    run_frame(6'h03, 8'h5A, 0, 1'b0, 8'h00, 8'h00);
    finish_frame(0);

    // R1 R2 R3 R4: sweep all framing settings
    for (int c = 0; c < 64; c++) begin
      single(6'(c), 8'h00);
      single(6'(c), 8'hFF);
      single(6'(c), 8'hA5);
      single(6'(c), 8'h3C ^ 8'(c));
    end

    // R9 R10: back-to-back, pending character overwritten
    lcr_i = 7'h1B;
    wr1(8'h81);
    run_frame(6'h1B, 8'h81, 0, 1'b1, 8'h11, 8'hC6);
    run_frame(6'h1B, 8'hC6, 0, 1'b0, 8'h00, 8'h00);
    finish_frame(0);

    // R11: fields captured at load, later changes ignored for this frame
    lcr_i = 7'h0F;
    wr1(8'h96);
    lcr_i = 7'h0F;
    tick1();
    chk("R11 start bit", int'(txd_o), 0);
    lcr_i = 7'h00;
    for (int k = 1; k < nticks(6'h0F); k++) begin
      tick1();
      chk("R11 captured frame", int'(txd_o), int'(ebit(6'h0F, 8'h96, k / TPB)));
    end
    finish_frame(0);

    // R5: break over whole frame, then released partway through a frame
    lcr_i = 7'h47;
    wr1(8'hE3);
    run_frame(6'h07, 8'hE3, 1000, 1'b0, 8'h00, 8'h00);
    finish_frame(1);
    @(negedge clk_i);
    chk("R5 line after break clear", int'(txd_o), 1);
    lcr_i = 7'h4E;
    wr1(8'h2D);
    run_frame(6'h0E, 8'h2D, 7, 1'b0, 8'h00, 8'h00);
    finish_frame(0);

    summary();
  end
endmodule